// File: doc/BRIEF.md
# Unaligned Load Byte-Merge Unit

This unit produces the register write-back value for the two partial-word load operations that together assemble a 32-bit word from an address that is not word aligned. A plain word load needs a 4-byte aligned address. To reach an unaligned word, software issues two slower operations instead: a left form and a right form. Each one reads only the single aligned memory word that holds its target byte. Each replaces only part of the destination register and keeps the remaining bytes of the value that was already there.

Each request presents four things: the aligned memory word, the low two address bits (the byte offset), a left/right select and the current destination register value. One clock later the unit returns the merged value with a valid flag. Lanes are numbered little-endian: lane k is bits [8k+7:8k], and byte offset o names lane o of the fetched word. To load the word at byte address A, issue the left form at address A+3, then issue the right form at address A with the first result fed back as the register value. The register then holds the bytes at A..A+3, with byte A in lane 0.

Top module: `unaligned_load_merge`

## Requirements
- R1: A request accepted with `in_valid` high produces `out_valid` high and its result on `merged` exactly one clock later.
- R2: Left form (`is_left`=1) at offset o: result lane (3-o+i) equals fetched lane i for i = 0..o, so fetched lane o lands in lane 3.
- R3: Left form at offset o: result lanes 0 .. (2-o) equal the corresponding lanes of `rd_old`.
- R4: Right form (`is_left`=0) at offset o: result lane i equals fetched lane (o+i) for i = 0..(3-o), so fetched lane o lands in lane 0.
- R5: Right form at offset o: result lanes (4-o) .. 3 equal the corresponding lanes of `rd_old`.
- R6: The left form at address A+3 followed by the right form at address A, with the first result used as `rd_old` of the second, yields the four bytes at A..A+3 with byte A in lane 0, for every A.
- R7: The left form at offset 3 and the right form at offset 0 each return the fetched word unchanged, whatever `rd_old` holds.
- R8: A cycle with `in_valid` low leaves `merged` unchanged and drives `out_valid` low one clock later.
- R9: While `rst_n` is low, `out_valid` and `merged` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| is_left | input | 1 | 1 selects the left form, 0 the right form |
| addr_lo | input | 2 | Low two bits of the effective byte address |
| mem_word | input | 32 | Aligned memory word holding the target byte |
| rd_old | input | 32 | Current destination register value |
| out_valid | output | 1 | Result valid, one cycle after the request |
| merged | output | 32 | Merged value to write back |

## Verification
Every form is driven at all four offsets. Random fetched words and random register values are used so that a lane copied from the wrong source shows up as a mismatch. Directed cases pair an all-ones register with a zero word, and the reverse, so that each lane shows plainly whether it was kept or replaced. This separates an off-by-one split point from a mirrored lane order. Chained left-then-right pairs over a random byte array cover every start address modulo 4 and confirm that the two halves meet without overlap or gap. Idle cycles with changed inputs show that the output holds.

// File: rtl/ulm_pkg.sv
package ulm_pkg;

    localparam int unsigned WORD_W_DEF = 32;
    localparam int unsigned LANE_W_DEF = 8;

    // Which half of the register a partial load fills.
    typedef enum logic {
        SIDE_RIGHT = 1'b0,
        SIDE_LEFT  = 1'b1
    } side_e;

endpackage

// File: rtl/ulm_lane_mask.sv
// Marks the destination lanes that receive fetched bytes.
module ulm_lane_mask #(
    parameter int unsigned LANES = 4,
    parameter int unsigned OFF_W = 2
) (
    input  logic [OFF_W-1:0] off,
    input  ulm_pkg::side_e   side,
    output logic [LANES-1:0] take
);

    // Boundary lane: left form fills from here upward, right form from here down.
    logic [OFF_W:0] split_lane;

    assign split_lane = (OFF_W+1)'(LANES-1) - {1'b0, off};

    for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
        localparam logic [OFF_W:0] LANE_IDX = (OFF_W+1)'(j);
        assign take[j] = (side == ulm_pkg::SIDE_LEFT) ? (LANE_IDX >= split_lane)
                                                      : (LANE_IDX <= split_lane);
    end

endmodule

// File: rtl/ulm_lane_shift.sv
// Moves fetched lanes into their destination positions.
module ulm_lane_shift #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned OFF_W  = 2
) (
    input  logic [LANES*LANE_W-1:0] word,
    input  logic [OFF_W-1:0]        off,
    input  ulm_pkg::side_e          side,
    output logic [LANES*LANE_W-1:0] shifted
);

    for (genvar j = 0; j < int'(LANES); j++) begin : g_dst
        logic [LANE_W-1:0] lane_v;

        always_comb begin
            lane_v = '0;
            for (int s = 0; s < int'(LANES); s++) begin
                if (side == ulm_pkg::SIDE_LEFT) begin
                    // source lane s moves up by (LANES-1-off)
                    if (s + int'(LANES) - 1 == j + int'(off)) begin
                        lane_v = word[s*LANE_W +: LANE_W];
                    end
                end else begin
                    // source lane s moves down by off
                    if (s == j + int'(off)) begin
                        lane_v = word[s*LANE_W +: LANE_W];
                    end
                end
            end
        end

        assign shifted[j*LANE_W +: LANE_W] = lane_v;
    end

endmodule

// File: rtl/ulm_lane_merge.sv
// Per lane: fetched data where marked, old register data elsewhere.
module ulm_lane_merge #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES-1:0]        take,
    input  logic [LANES*LANE_W-1:0] fresh,
    input  logic [LANES*LANE_W-1:0] keep,
    output logic [LANES*LANE_W-1:0] result
);

    for (genvar j = 0; j < int'(LANES); j++) begin : g_sel
        assign result[j*LANE_W +: LANE_W] = take[j] ? fresh[j*LANE_W +: LANE_W]
                                                    : keep[j*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/unaligned_load_merge.sv
module unaligned_load_merge #(
    parameter int unsigned DATA_W = ulm_pkg::WORD_W_DEF,
    parameter int unsigned LANE_W = ulm_pkg::LANE_W_DEF,
    localparam int unsigned LANES = DATA_W / LANE_W,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              is_left,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] rd_old,
    output logic              out_valid,
    output logic [DATA_W-1:0] merged
);

    localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(LANES - 1);
    localparam int unsigned      LOW_W   = DATA_W - LANE_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } state_t;

    ulm_pkg::side_e    side_sel;
    logic [LANES-1:0]  take_c;
    logic [DATA_W-1:0] shifted_c;
    logic [DATA_W-1:0] merged_c;
    state_t            state_d;
    state_t            state_q;

    assign side_sel = is_left ? ulm_pkg::SIDE_LEFT : ulm_pkg::SIDE_RIGHT;

    ulm_lane_mask #(
        .LANES (LANES),
        .OFF_W (OFF_W)
    ) u_mask (
        .off  (addr_lo),
        .side (side_sel),
        .take (take_c)
    );

    ulm_lane_shift #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .OFF_W  (OFF_W)
    ) u_shift (
        .word    (mem_word),
        .off     (addr_lo),
        .side    (side_sel),
        .shifted (shifted_c)
    );

    ulm_lane_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_merge (
        .take   (take_c),
        .fresh  (shifted_c),
        .keep   (rd_old),
        .result (merged_c)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.data = merged_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign merged    = state_q.data;

    // R1: one-cycle result latency
    a_r1_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: the byte at the offset becomes the top lane on a left form
    a_r2_left_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_left) |=>
        merged[DATA_W-1 -: LANE_W] == $past(mem_word[addr_lo*LANE_W +: LANE_W]));

    // R3: a left form at offset 0 keeps every lower lane of the register
    a_r3_left_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_left && addr_lo == '0) |=>
        merged[LOW_W-1:0] == $past(rd_old[LOW_W-1:0]));

    // R4: the byte at the offset becomes lane 0 on a right form
    a_r4_right_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_left) |=>
        merged[LANE_W-1:0] == $past(mem_word[addr_lo*LANE_W +: LANE_W]));

    // R5: a right form at the last offset keeps every upper lane of the register
    a_r5_right_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_left && addr_lo == OFF_MAX) |=>
        merged[DATA_W-1:LANE_W] == $past(rd_old[DATA_W-1:LANE_W]));

    // R7: full-word cases copy the fetched word
    a_r7_left_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_left && addr_lo == OFF_MAX) |=> merged == $past(mem_word));

    a_r7_right_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_left && addr_lo == '0) |=> merged == $past(mem_word));

    // R8: idle cycles hold the result and drop the valid flag
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(merged)));

endmodule

// File: tb/sim_unaligned_load_merge.sv
module sim_unaligned_load_merge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        is_left = 1'b0;
    logic [1:0]  addr_lo = 2'd0;
    logic [31:0] mem_word = '0;
    logic [31:0] rd_old = '0;
    logic        out_valid;
    logic [31:0] merged;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] bytes_q [16];

    always #2 clk = ~clk;

    unaligned_load_merge u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .is_left  (is_left),
        .addr_lo  (addr_lo),
        .mem_word (mem_word),
        .rd_old   (rd_old),
        .out_valid(out_valid),
        .merged   (merged)
    );

    function automatic logic [31:0] model(bit left, int o, logic [31:0] w, logic [31:0] old);
        logic [31:0] r = old;
        if (left) begin
            for (int i = 0; i <= o; i++) r[(3-o+i)*8 +: 8] = w[i*8 +: 8];
        end else begin
            for (int i = 0; i <= 3-o; i++) r[i*8 +: 8] = w[(o+i)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] word_at(int a);
        return {bytes_q[a+3], bytes_q[a+2], bytes_q[a+1], bytes_q[a]};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Drive one request, return the registered result sampled after the edge.
    task automatic issue(bit left, int o, logic [31:0] w, logic [31:0] old,
                         output logic [31:0] res);
        @(negedge clk);
        in_valid = 1'b1;
        is_left  = left;
        addr_lo  = 2'(o);
        mem_word = w;
        rd_old   = old;
        @(posedge clk);
        #1;
        check("R1 out_valid", {31'd0, out_valid}, 32'd1);
        res = merged;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] res;
        logic [31:0] first;
        logic [31:0] w;
        logic [31:0] old;
        void'($urandom(32'h5eed_1234));

        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9 out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 merged", merged, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5: all-ones register against zero word, then the reverse
        for (int o = 0; o < 4; o++) begin
            issue(1'b1, o, 32'h0000_0000, 32'hFFFF_FFFF, res);
            check($sformatf("R3 left keep o=%0d", o), res, model(1, o, 32'h0, 32'hFFFF_FFFF));
            issue(1'b0, o, 32'hFFFF_FFFF, 32'h0000_0000, res);
            check($sformatf("R5 right keep o=%0d", o), res, model(0, o, 32'hFFFF_FFFF, 32'h0));
            issue(1'b1, o, 32'h4433_2211, 32'hDDCC_BBAA, res);
            check($sformatf("R2 left order o=%0d", o), res, model(1, o, 32'h4433_2211, 32'hDDCC_BBAA));
            issue(1'b0, o, 32'h4433_2211, 32'hDDCC_BBAA, res);
            check($sformatf("R4 right order o=%0d", o), res, model(0, o, 32'h4433_2211, 32'hDDCC_BBAA));
        end

        // R7: full-word cases ignore the register value
        for (int k = 0; k < 8; k++) begin
            w   = $urandom;
            old = $urandom;
            issue(1'b1, 3, w, old, res);
            check("R7 left offset 3", res, w);
            issue(1'b0, 0, w, old, res);
            check("R7 right offset 0", res, w);
        end

        // R8: idle cycle with changed inputs holds the result
        issue(1'b1, 1, 32'h1234_5678, 32'h9ABC_DEF0, res);
        @(negedge clk);
        in_valid = 1'b0;
        mem_word = 32'hFFFF_FFFF;
        rd_old   = 32'h0000_0000;
        is_left  = 1'b0;
        addr_lo  = 2'd2;
        @(posedge clk);
        #1;
        check("R8 hold merged", merged, res);
        check("R8 out_valid low", {31'd0, out_valid}, 32'd0);
        @(posedge clk);
        #1;
        check("R8 hold second idle", merged, res);

        // R6: worked example, bytes 4..7 left at 6 then bytes 0..3 right at 3
        for (int b = 0; b < 16; b++) bytes_q[b] = 8'(8'h10 + b);
        issue(1'b1, 2, word_at(4), 32'hEEEE_EEEE, first);
        check("R6 example left", first, {bytes_q[6], bytes_q[5], bytes_q[4], 8'hEE});
        issue(1'b0, 3, word_at(0), first, res);
        check("R6 example pair", res, word_at(3));

        // R6: random byte arrays, every start address
        for (int rep = 0; rep < 40; rep++) begin
            for (int b = 0; b < 16; b++) bytes_q[b] = 8'($urandom);
            for (int a = 0; a <= 12; a++) begin
                old = $urandom;
                issue(1'b1, (a+3) % 4, word_at(((a+3)/4)*4), old, first);
                issue(1'b0, a % 4, word_at((a/4)*4), first, res);
                check($sformatf("R6 pair addr %0d", a), res, word_at(a));
            end
        end

        // R2 R3 R4 R5: random mix, with idle gaps (R8)
        for (int k = 0; k < 1500; k++) begin
            bit left = 1'($urandom);
            int o = int'($urandom % 4);
            w   = $urandom;
            old = $urandom;
            issue(left, o, w, old, res);
            check(left ? "R2/R3 random left" : "R4/R5 random right", res, model(left, o, w, old));
            if (($urandom % 5) == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                mem_word = $urandom;
                @(posedge clk);
                #1;
                check("R8 random idle", merged, res);
            end
        end

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule